// File: doc/BRIEF.md
# Signed Word Multiply Execute Unit

This block executes one 16-bit instruction word at a time against its own bank of eight 32-bit data registers. A word that encodes a signed multiply with a data-register source takes the low halves of the source and destination registers and treats each as a signed 16-bit number. It multiplies them into a signed 32-bit product and stores that product over the whole destination register. Any other word is refused: an illegal flag is raised and no register changes.

Instruction words arrive on a valid/ready command interface. A word is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for the one cycle in which the taken word is being executed. While `cmd_ready` is low, the source keeps `cmd_valid` high and `cmd_word` unchanged. The result is written on the edge that follows the accepting edge. `done` is high for exactly the cycle after that write. `illegal` is high in the same cycle when the word was refused.

A separate register-file port lets the surrounding logic load and inspect the registers. It has a synchronous write and a combinational read.

Top module: `smul_exec_unit`

## Requirements
- R1: A word is a supported multiply only when bits 15:12 are 1100, bits 8:6 are 111 and bits 5:3 are 000. Bits 11:9 select the destination register and bits 2:0 select the source register.
- R2: The operands are bits 15:0 of the source and destination registers, each sign-extended to 32 bits. The value written is the signed 32-bit product; for example, 0xFFFD times 0x0006 gives 0xFFFFFFEE, and 0x0073 times 0x0295 gives 0x000128EF.
- R3: The product replaces all 32 bits of the destination register, and every other register, including a distinct source, keeps its value.
- R4: For a word that is not a supported multiply, `illegal` is high in the same cycle as `done`, and no register is written.
- R5: For each accepted word, `cmd_ready` is low in the following cycle. The register write happens on the next edge, and `done` is then high for exactly one cycle, during which the new value is visible on the read port.
- R6: After reset, all registers read zero, `done` and `illegal` are low, and `cmd_ready` is high.
- R7: `rf_wr_en` writes `rf_wr_data` into register `rf_wr_addr` on the clock edge. When the unit writes the same register on the same edge, the unit's product wins. Operands are taken from register values as they stood before the accepting edge.
- R8: While `cmd_ready` is low, a held word is not taken; it is taken on the first edge on which `cmd_ready` is high.
- R9: The most negative word times itself (0x8000 times 0x8000) gives 0x40000000, and a register used as both source and destination is squared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Unit can take a word this cycle |
| cmd_word | input | 16 | Instruction word |
| done | output | 1 | One-cycle pulse after a word completes |
| illegal | output | 1 | Completed word was not a supported multiply |
| rf_wr_en | input | 1 | External register write enable |
| rf_wr_addr | input | 3 | External write register number |
| rf_wr_data | input | REG_W (32) | External write data |
| rf_rd_addr | input | 3 | External read register number |
| rf_rd_data | output | REG_W (32) | Register contents, combinational |

## Verification
The bench uses the default parameters: 32-bit registers and 16-bit operands. With these values the upper halves of the registers are replaced in full, so sign extension and upper-half clobbering are visible at the read port. The 0x8000 squared corner also lands exactly on the boundary of the product width. Register values are drawn from a mix of these extremes and random values. This lets the random multiplies cover sign combinations, a shared source and destination, and a collision with an external write.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int INSTR_W = 16;
  localparam int SEL_W   = 3;
  localparam int NREGS   = 1 << SEL_W;

  localparam logic [3:0] OPC_MUL     = 4'b1100;
  localparam logic [2:0] OPMODE_SMUL = 3'b111;
  localparam logic [2:0] SMODE_DREG  = 3'b000;

  typedef struct packed {
    logic [3:0]       opc;
    logic [SEL_W-1:0] dst;
    logic [2:0]       opmode;
    logic [2:0]       smode;
    logic [SEL_W-1:0] src;
  } iword_t;
endpackage

// File: rtl/smul_decode.sv
module smul_decode
  import smul_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic               legal,
  output logic [SEL_W-1:0]   dst,
  output logic [SEL_W-1:0]   src
);
  iword_t f;

  always_comb begin
    f     = iword_t'(word);
    legal = (f.opc == OPC_MUL) && (f.opmode == OPMODE_SMUL) && (f.smode == SMODE_DREG);
    dst   = f.dst;
    src   = f.src;
  end
endmodule

// File: rtl/smul_regfile.sv
module smul_regfile
  import smul_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int OPND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_we,
  input  logic [SEL_W-1:0]  ext_waddr,
  input  logic [REG_W-1:0]  ext_wdata,
  input  logic              unit_we,
  input  logic [SEL_W-1:0]  unit_waddr,
  input  logic [REG_W-1:0]  unit_wdata,
  input  logic [SEL_W-1:0]  opa_addr,
  output logic [OPND_W-1:0] opa_data,
  input  logic [SEL_W-1:0]  opb_addr,
  output logic [OPND_W-1:0] opb_data,
  input  logic [SEL_W-1:0]  ext_raddr,
  output logic [REG_W-1:0]  ext_rdata
);
  logic [REG_W-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (unit_we && unit_waddr == SEL_W'(i))
          regs[i] <= unit_wdata;
        else if (ext_we && ext_waddr == SEL_W'(i))
          regs[i] <= ext_wdata;
      end
    end
  end

  assign opa_data  = regs[opa_addr][OPND_W-1:0];
  assign opb_data  = regs[opb_addr][OPND_W-1:0];
  assign ext_rdata = regs[ext_raddr];
endmodule

// File: rtl/smul_mult.sv
module smul_mult #(
  parameter int OPND_W = 16,
  parameter int REG_W  = 32
) (
  input  logic [OPND_W-1:0] a,
  input  logic [OPND_W-1:0] b,
  output logic [REG_W-1:0]  p
);
  localparam int PW = 2 * OPND_W;

  logic signed [PW-1:0] full;
  assign full = $signed(a) * $signed(b);

  generate
    if (REG_W > PW) begin : g_ext
      assign p = {{(REG_W-PW){full[PW-1]}}, full};
    end else if (REG_W == PW) begin : g_eq
      assign p = full;
    end else begin : g_trunc
      assign p = full[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/smul_exec_unit.sv
module smul_exec_unit
  import smul_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int OPND_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [INSTR_W-1:0] cmd_word,
  output logic               done,
  output logic               illegal,
  input  logic               rf_wr_en,
  input  logic [SEL_W-1:0]   rf_wr_addr,
  input  logic [REG_W-1:0]   rf_wr_data,
  input  logic [SEL_W-1:0]   rf_rd_addr,
  output logic [REG_W-1:0]   rf_rd_data
);
  logic              accept;
  logic              dec_legal;
  logic [SEL_W-1:0]  dec_dst, dec_src;
  logic [OPND_W-1:0] src_lo, dst_lo;

  logic              busy;
  logic              st_legal;
  logic [SEL_W-1:0]  st_dst;
  logic [OPND_W-1:0] st_a, st_b;
  logic [REG_W-1:0]  product;
  logic              res_we;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign res_we    = busy && st_legal;

  smul_decode u_dec (
    .word  (cmd_word),
    .legal (dec_legal),
    .dst   (dec_dst),
    .src   (dec_src)
  );

  smul_regfile #(.REG_W(REG_W), .OPND_W(OPND_W)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_we     (rf_wr_en),
    .ext_waddr  (rf_wr_addr),
    .ext_wdata  (rf_wr_data),
    .unit_we    (res_we),
    .unit_waddr (st_dst),
    .unit_wdata (product),
    .opa_addr   (dec_src),
    .opa_data   (src_lo),
    .opb_addr   (dec_dst),
    .opb_data   (dst_lo),
    .ext_raddr  (rf_rd_addr),
    .ext_rdata  (rf_rd_data)
  );

  smul_mult #(.OPND_W(OPND_W), .REG_W(REG_W)) u_mul (
    .a (st_a),
    .b (st_b),
    .p (product)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      st_legal <= 1'b0;
      st_dst   <= '0;
      st_a     <= '0;
      st_b     <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      busy    <= accept;
      done    <= busy;
      illegal <= busy && !st_legal;
      if (accept) begin
        st_legal <= dec_legal;
        st_dst   <= dec_dst;
        st_a     <= src_lo;
        st_b     <= dst_lo;
      end
    end
  end
endmodule

// File: rtl/smul_exec_chk.sv
module smul_exec_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic illegal,
  input logic res_we
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready ##1 done));

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R4
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R4
  write_then_legal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (done && !illegal));

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!done && !illegal));
endmodule

bind smul_exec_unit smul_exec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .illegal   (illegal),
  .res_we    (res_we)
);

// File: tb/smul_exec_unit_bench.sv
`timescale 1ns/1ps
module smul_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic        done, illegal;
  logic        rf_wr_en = 1'b0;
  logic [2:0]  rf_wr_addr = '0;
  logic [31:0] rf_wr_data = '0;
  logic [2:0]  rf_rd_addr = '0;
  logic [31:0] rf_rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  smul_exec_unit u_smul_exec_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .done(done), .illegal(illegal),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data)
  );

  function automatic bit is_legal(input logic [15:0] w);
    return (w[15:12] == 4'b1100) && (w[8:6] == 3'b111) && (w[5:3] == 3'b000);
  endfunction

  function automatic logic [31:0] smul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] x, y;
    x = {{16{a[15]}}, a};
    y = {{16{b[15]}}, b};
    return x * y;
  endfunction

  function automatic logic [15:0] mk(input logic [2:0] d, input logic [2:0] s);
    return {4'b1100, d, 3'b111, 3'b000, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ext_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_addr = a; rf_wr_data = d;
    @(negedge clk);
    rf_wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rf_rd_addr = 3'(i);
      #0.2;
      chk(req, rf_rd_data, model[i]);
    end
  endtask

  // one word, optionally with an external write during the execute cycle
  task automatic run_op(input logic [15:0] w, input bit side_we,
                        input logic [2:0] side_a, input logic [31:0] side_d);
    logic [31:0] prod;
    bit ok;
    ok   = is_legal(w);
    prod = smul(model[w[2:0]][15:0], model[w[11:9]][15:0]);
    @(negedge clk);
    chk("R5 done low before accept", {31'b0, done}, 32'd0);
    chk("R5 ready when idle", {31'b0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 ready low while executing", {31'b0, cmd_ready}, 32'd0);
    chk("R5 done low while executing", {31'b0, done}, 32'd0);
    if (side_we) begin
      rf_wr_en = 1'b1; rf_wr_addr = side_a; rf_wr_data = side_d;
      model[side_a] = side_d;
    end
    if (ok) model[w[11:9]] = prod;
    @(negedge clk);
    rf_wr_en = 1'b0;
    chk("R5 done pulse", {31'b0, done}, 32'd1);
    chk("R4 illegal flag", {31'b0, illegal}, {31'b0, !ok});
    rf_rd_addr = w[11:9];
    #0.2;
    chk("R3 destination value", rf_rd_data, model[w[11:9]]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk("R6 done after reset", {31'b0, done}, 32'd0);
    chk("R6 illegal after reset", {31'b0, illegal}, 32'd0);
    chk("R6 ready after reset", {31'b0, cmd_ready}, 32'd1);
    compare_all("R6 registers zero");

    // R2 negative times positive, word C5C1: d1 source, d2 destination
    ext_write(3'd1, 32'hF348FFFD);
    ext_write(3'd2, 32'h12340006);
    run_op(16'hC5C1, 1'b0, 3'd0, '0);
    chk("R2 -3 x 6", model[2], 32'hFFFFFFEE);
    compare_all("R3 source untouched");

    // R2 two positives: d3 source, d0 destination
    ext_write(3'd3, 32'hD3AB0073);
    ext_write(3'd0, 32'hF0000295);
    run_op(mk(3'd0, 3'd3), 1'b0, 3'd0, '0);
    rf_rd_addr = 3'd0; #0.2;
    chk("R2 115 x 661", rf_rd_data, 32'h000128EF);

    // R9 most negative squared, shared source and destination
    ext_write(3'd4, 32'h00018000);
    run_op(mk(3'd4, 3'd4), 1'b0, 3'd0, '0);
    rf_rd_addr = 3'd4; #0.2;
    chk("R9 8000 squared", rf_rd_data, 32'h40000000);

    // R1 R4 near misses: wrong opcode, wrong opmode, memory source mode
    run_op(16'hD5C1, 1'b0, 3'd0, '0);
    run_op(16'hC5C1 & 16'hFF7F, 1'b0, 3'd0, '0);
    run_op(16'hC5D1, 1'b0, 3'd0, '0);
    compare_all("R4 no write on illegal");

    // R7 external write collides with the unit write / hits another register
    run_op(mk(3'd2, 3'd1), 1'b1, 3'd2, 32'hDEADBEEF);
    run_op(mk(3'd5, 3'd6), 1'b1, 3'd6, 32'h0000ABCD);
    compare_all("R7 write priority");

    // R8 word held while ready is low
    ext_write(3'd7, 32'h00000003);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = mk(3'd7, 3'd7);
    @(negedge clk);
    cmd_word = mk(3'd6, 3'd7);
    chk("R8 ready low", {31'b0, cmd_ready}, 32'd0);
    @(negedge clk);
    chk("R8 first done", {31'b0, done}, 32'd1);
    rf_rd_addr = 3'd7; #0.2;
    chk("R8 first result", rf_rd_data, 32'h00000009);
    model[7] = 32'h00000009;
    model[6] = smul(16'h0009, model[6][15:0]);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 held word taken", {31'b0, cmd_ready}, 32'd0);
    @(negedge clk);
    chk("R8 second done", {31'b0, done}, 32'd1);
    compare_all("R8 held word result");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [15:0] w;
      r = int'($urandom % 10);
      if (r < 2) begin
        int c;
        c = int'($urandom % 4);
        ext_write(3'($urandom), c == 0 ? 32'h00008000 : c == 1 ? 32'hFFFF7FFF : $urandom);
      end
      r = int'($urandom % 10);
      if (r < 7) w = mk(3'($urandom), 3'($urandom));
      else if (r < 9) w = mk(3'($urandom), 3'($urandom)) ^ (16'h1 << (3 + ($urandom % 13)));
      else w = 16'($urandom);
      r = int'($urandom % 8);
      run_op(w, r == 0, 3'($urandom), $urandom);
      if (n % 25 == 24) compare_all("R3 random register file");
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule